// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides, in the cycle a decoded branch is presented, whether a 32-bit fetch unit redirects and to which address. It receives the current instruction address, a two-bit branch kind, an absolute-address flag, a link flag, a five-bit option field, a five-bit condition-bit selector, a word displacement and the 32-bit condition register. It returns a taken flag and the next fetch address in the same cycle.

The block holds the loop count register and the return-address register. A branch may step the count register down by one, test the result against zero and test one condition bit, all in one evaluation. A branch may also save the return address, which turns it into a call. Both registers can be loaded from outside while no branch is presented. Their new values appear on the outputs one clock after the update.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low, and for two clocks after it rises, `ctr_o` and `lr_o` read zero. `taken_o` is low whenever `valid_i` is low.
- R2: Kind 0 is an unconditional immediate branch and is always taken. The displacement is a signed word offset: it is shifted left by two and sign-extended. With `abs_i`=1 it is the target; with `abs_i`=0 the target is `pc_i` plus it. `abs_i` also applies to kind 1.
- R3: The condition test passes when `bo_i[4]`=1, or when `cr_i[bi_i]` equals `bo_i[3]`. Bit 0 of `cr_i` is its least significant bit.
- R4: For kinds 1 and 2 with `bo_i[2]`=0, the count is decremented before the zero test. With `bo_i[1]`=1 the test passes on a zero result; with `bo_i[1]`=0 it passes on a non-zero result. The decremented value shows on `ctr_o` after the clock, whether or not the branch is taken.
- R5: With `bo_i[2]`=1 the count register is neither decremented nor tested.
- R6: Kind 2 takes its target from the return-address register and kind 3 from the count register. In both cases the two low bits are forced to zero and the value held before the clock edge is used.
- R7: A kind-3 branch with `bo_i[2]`=0 is invalid. It is not taken and leaves the count register unchanged.
- R8: With `link_i`=1 on a valid branch, `lr_o` becomes `pc_i`+4 after the clock, taken or not. A kind-2 branch with `link_i`=1 jumps to the old return address.
- R9: When `taken_o` is low, `next_pc_o` equals `pc_i`+4. When `valid_i` is low, no register changes unless it is loaded.
- R10: `ctr_ld_i` and `lr_ld_i` write `ld_data_i` into their register while `valid_i` is low. While `valid_i` is high, both loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A decoded branch is presented this cycle |
| kind_i | input | 2 | 0 unconditional imm, 1 conditional imm, 2 conditional to return register, 3 conditional to count register |
| abs_i | input | 1 | Immediate target is absolute |
| link_i | input | 1 | Save the return address |
| bo_i | input | 5 | Branch option field |
| bi_i | input | 5 | Condition bit selector |
| disp_i | input | 24 | Signed word displacement |
| pc_i | input | 32 | Current instruction address |
| cr_i | input | 32 | Condition register |
| ctr_ld_i | input | 1 | Load the count register |
| lr_ld_i | input | 1 | Load the return-address register |
| ld_data_i | input | 32 | Load value |
| taken_o | output | 1 | Branch is taken |
| next_pc_o | output | 32 | Next fetch address |
| ctr_o | output | 32 | Count register |
| lr_o | output | 32 | Return-address register |

## Verification
A wrong count value shows up two ways. It appears on `ctr_o` one clock after the faulty update. It also shows at the next count-testing branch, as a wrong `taken_o` in the same cycle that branch is presented. The decrement sequence therefore runs the count down through one, zero and the wrap past zero. A bad return-address value shows on `lr_o` after one clock, and on `next_pc_o` at the next kind-2 branch. A wrong choice of target shows on `next_pc_o` in the same cycle the branch is presented.

// File: rtl/brres_pkg.sv
package brres_pkg;
  typedef enum logic [1:0] {
    BK_JUMP     = 2'd0,
    BK_COND_IMM = 2'd1,
    BK_COND_LR  = 2'd2,
    BK_COND_CTR = 2'd3
  } br_kind_e;
endpackage

// File: rtl/br_rst_sync.sv
module br_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
  parameter int XLEN = 32
) (
  input  brres_pkg::br_kind_e kind,
  input  logic [4:0]          bo,
  input  logic                cr_bit,
  input  logic [XLEN-1:0]     ctr_q,
  output logic                taken,
  output logic                dec_en,
  output logic [XLEN-1:0]     ctr_dec
);
  import brres_pkg::*;

  logic is_jump, bad_form, ctr_zero, ctr_ok, cond_ok;
  logic [XLEN-1:0] ctr_seen;

  always_comb begin
    is_jump  = (kind == BK_JUMP);
    bad_form = (kind == BK_COND_CTR) && !bo[2];
    dec_en   = !is_jump && !bo[2] && !bad_form;
    ctr_dec  = ctr_q - XLEN'(1);
    ctr_seen = dec_en ? ctr_dec : ctr_q;
    ctr_zero = (ctr_seen == '0);
    ctr_ok   = bo[2] || (ctr_zero == bo[1]);
    cond_ok  = bo[4] || (cr_bit == bo[3]);
    taken    = is_jump || (!bad_form && ctr_ok && cond_ok);
  end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 24
) (
  input  brres_pkg::br_kind_e kind,
  input  logic                abs_addr,
  input  logic [DISP_W-1:0]   disp,
  input  logic [XLEN-1:0]     pc,
  input  logic [XLEN-1:0]     lr_q,
  input  logic [XLEN-1:0]     ctr_q,
  output logic [XLEN-1:0]     target
);
  import brres_pkg::*;

  localparam int EXT_W = XLEN - DISP_W - 2;
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  logic [XLEN-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    case (kind)
      BK_COND_LR:  target = lr_q & ALIGN_MASK;
      BK_COND_CTR: target = ctr_q & ALIGN_MASK;
      default:     target = abs_addr ? disp_ext : (pc + disp_ext);
    endcase
  end
endmodule

// File: rtl/br_regs.sv
module br_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_q_n,
  input  logic            ctr_we,
  input  logic [XLEN-1:0] ctr_d,
  input  logic            lr_we,
  input  logic [XLEN-1:0] lr_d,
  output logic [XLEN-1:0] ctr_q,
  output logic [XLEN-1:0] lr_q
);
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    ctr_q <= '0;
    else if (ctr_we) ctr_q <= ctr_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   lr_q <= '0;
    else if (lr_we) lr_q <= lr_d;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 24,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic              abs_i,
  input  logic              link_i,
  input  logic [4:0]        bo_i,
  input  logic [SEL_W-1:0]  bi_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   cr_i,
  input  logic              ctr_ld_i,
  input  logic              lr_ld_i,
  input  logic [XLEN-1:0]   ld_data_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   ctr_o,
  output logic [XLEN-1:0]   lr_o
);
  import brres_pkg::*;

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic            rst_q_n;
  br_kind_e        kind;
  logic            cond_taken, dec_en;
  logic [XLEN-1:0] ctr_dec, target, seq_pc;
  logic [XLEN-1:0] ctr_q, lr_q, ctr_d, lr_d;
  logic            ctr_we, lr_we;

  assign kind = br_kind_e'(kind_i);

  br_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  br_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind    (kind),
    .bo      (bo_i),
    .cr_bit  (cr_i[bi_i]),
    .ctr_q   (ctr_q),
    .taken   (cond_taken),
    .dec_en  (dec_en),
    .ctr_dec (ctr_dec)
  );

  br_target_gen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
    .kind     (kind),
    .abs_addr (abs_i),
    .disp     (disp_i),
    .pc       (pc_i),
    .lr_q     (lr_q),
    .ctr_q    (ctr_q),
    .target   (target)
  );

  // next-state selection for the owned registers
  always_comb begin
    seq_pc = pc_i + INSN_BYTES;
    if (valid_i) begin
      ctr_we = dec_en;
      ctr_d  = ctr_dec;
      lr_we  = link_i;
      lr_d   = seq_pc;
    end else begin
      ctr_we = ctr_ld_i;
      ctr_d  = ld_data_i;
      lr_we  = lr_ld_i;
      lr_d   = ld_data_i;
    end
    taken_o   = valid_i && cond_taken;
    next_pc_o = taken_o ? target : seq_pc;
  end

  br_regs #(.XLEN(XLEN)) u_regs (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .ctr_we  (ctr_we),
    .ctr_d   (ctr_d),
    .lr_we   (lr_we),
    .lr_d    (lr_d),
    .ctr_q   (ctr_q),
    .lr_q    (lr_q)
  );

  assign ctr_o = ctr_q;
  assign lr_o  = lr_q;
endmodule

// File: rtl/br_checker.sv
module br_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [1:0]      kind_i,
  input logic            link_i,
  input logic [4:0]      bo_i,
  input logic [XLEN-1:0] pc_i,
  input logic            taken_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic [XLEN-1:0] ctr_o,
  input logic [XLEN-1:0] lr_o
);
  assert_idle_not_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !taken_o);

  assert_jump_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 2'd0) |-> taken_o);

  assert_ctr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (kind_i == 2'd1 || kind_i == 2'd2) && !bo_i[2])
      |=> ctr_o == $past(ctr_o) - XLEN'(1));

  assert_ctr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i != 2'd0 && bo_i[2]) |=> $stable(ctr_o));

  assert_reg_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i[1] && taken_o) |-> next_pc_o[1:0] == 2'b00);

  assert_bad_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 2'd3 && !bo_i[2]) |-> !taken_o);

  assert_bad_form_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 2'd3 && !bo_i[2]) |=> $stable(ctr_o));

  assert_link_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && link_i) |=> lr_o == $past(pc_i) + XLEN'(4));

  assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> next_pc_o == pc_i + XLEN'(4));
endmodule

bind branch_resolver br_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .valid_i   (valid_i),
  .kind_i    (kind_i),
  .link_i    (link_i),
  .bo_i      (bo_i),
  .pc_i      (pc_i),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o),
  .ctr_o     (ctr_o),
  .lr_o      (lr_o)
);

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, abs_i, link_i, ctr_ld_i, lr_ld_i;
  logic [1:0]  kind_i;
  logic [4:0]  bo_i, bi_i;
  logic [23:0] disp_i;
  logic [31:0] pc_i, cr_i, ld_data_i;
  logic        taken_o;
  logic [31:0] next_pc_o, ctr_o, lr_o;

  branch_resolver u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
    .abs_i(abs_i), .link_i(link_i), .bo_i(bo_i), .bi_i(bi_i),
    .disp_i(disp_i), .pc_i(pc_i), .cr_i(cr_i), .ctr_ld_i(ctr_ld_i),
    .lr_ld_i(lr_ld_i), .ld_data_i(ld_data_i), .taken_o(taken_o),
    .next_pc_o(next_pc_o), .ctr_o(ctr_o), .lr_o(lr_o)
  );

  always #HALF clk = ~clk;

  typedef struct {
    logic        taken;
    logic [31:0] npc;
    logic [31:0] ctr;
    logic [31:0] lr;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] m_ctr = 0;
  logic [31:0] m_lr  = 0;
  bit          done  = 0;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference model built from the requirements
  task automatic br(input logic [1:0] k, input logic a, input logic l,
                    input logic [4:0] bo, input logic [4:0] bi,
                    input logic [31:0] cr, input logic [23:0] d,
                    input logic [31:0] pc, input string tag);
    exp_t e;
    logic [31:0] dx, tgt, c;
    logic dec, bad, ok_c, ok_r, tk;
    @(negedge clk);
    valid_i = 1; kind_i = k; abs_i = a; link_i = l; bo_i = bo; bi_i = bi;
    cr_i = cr; disp_i = d; pc_i = pc;
    dx  = {{6{d[23]}}, d, 2'b00};
    bad = (k == 2'd3) && !bo[2];
    dec = (k == 2'd1 || k == 2'd2) && !bo[2];
    c   = dec ? m_ctr - 1 : m_ctr;
    ok_r = bo[2] || ((c == 0) == bo[1]);
    ok_c = bo[4] || (cr[bi] == bo[3]);
    tk  = (k == 2'd0) || (!bad && ok_r && ok_c);
    case (k)
      2'd2:    tgt = {m_lr[31:2], 2'b00};
      2'd3:    tgt = {m_ctr[31:2], 2'b00};
      default: tgt = a ? dx : pc + dx;
    endcase
    m_ctr = c;
    if (l) m_lr = pc + 4;
    e.taken = tk; e.npc = tk ? tgt : pc + 4; e.ctr = m_ctr; e.lr = m_lr; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic lc, input logic ll, input logic [31:0] v,
                      input string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 0; ctr_ld_i = lc; lr_ld_i = ll; ld_data_i = v; pc_i = 32'h0000_0400;
    if (lc) m_ctr = v;
    if (ll) m_lr = v;
    e.taken = 0; e.npc = 32'h0000_0404; e.ctr = m_ctr; e.lr = m_lr; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: combinational results just before the edge, registers after it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic t;
        logic [31:0] n;
        e = sb_q.pop_front();
        #(HALF - 2);
        t = taken_o; n = next_pc_o;
        @(posedge clk);
        #1;
        checks++;
        if (t !== e.taken || n !== e.npc || ctr_o !== e.ctr || lr_o !== e.lr) begin
          errors++;
          $display("FAIL %s: taken=%0b npc=%h ctr=%h lr=%h expected taken=%0b npc=%h ctr=%h lr=%h",
                   e.tag, t, n, ctr_o, lr_o, e.taken, e.npc, e.ctr, e.lr);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired, expected the sequence to complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; valid_i = 0; kind_i = 0; abs_i = 0; link_i = 0; bo_i = 0; bi_i = 0;
    disp_i = 0; pc_i = 0; cr_i = 0; ctr_ld_i = 0; lr_ld_i = 0; ld_data_i = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (ctr_o !== 0 || lr_o !== 0 || taken_o !== 0) begin
      errors++;
      $display("FAIL R1: ctr=%h lr=%h taken=%0b expected 0 0 0", ctr_o, lr_o, taken_o);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);

    idle(1, 0, 32'd3, "R10 ctr load");
    idle(0, 1, 32'h2002, "R10 lr load");
    idle(0, 0, 32'hdead, "R9 idle no change");
    br(2'd0, 0, 0, 5'b00000, 0, 0, 24'd4, 32'h1000, "R2 relative fwd");
    br(2'd0, 1, 0, 5'b00000, 0, 0, 24'hffffff, 32'h1000, "R2 absolute neg");
    br(2'd0, 0, 0, 5'b00000, 0, 0, 24'hfffffe, 32'h1000, "R2 relative back");
    br(2'd1, 0, 0, 5'b10100, 0, 0, 24'd8, 32'h1000, "R5 always");
    br(2'd1, 0, 0, 5'b01100, 5'd5, 32'h20, 24'd8, 32'h1000, "R3 true hit");
    br(2'd1, 0, 0, 5'b01100, 5'd5, 32'hffff_ffdf, 24'd8, 32'h1000, "R3 true miss");
    br(2'd1, 1, 0, 5'b00100, 5'd31, 32'h7fff_ffff, 24'd64, 32'h1000, "R3 false hit abs");
    br(2'd1, 0, 0, 5'b10000, 0, 0, 24'd8, 32'h1000, "R4 nz 3to2");
    br(2'd1, 0, 0, 5'b10000, 0, 0, 24'd8, 32'h1000, "R4 nz 2to1");
    br(2'd1, 0, 0, 5'b10000, 0, 0, 24'd8, 32'h1000, "R4 nz 1to0 not taken");
    br(2'd1, 0, 0, 5'b10010, 0, 0, 24'd8, 32'h1000, "R4 zero wrap");
    idle(1, 0, 32'd1, "R10 ctr reload");
    br(2'd1, 0, 0, 5'b10010, 0, 0, 24'd8, 32'h1000, "R4 zero hit");
    idle(1, 0, 32'd5, "R10 ctr reload");
    br(2'd1, 0, 0, 5'b01000, 5'd2, 32'h4, 24'd8, 32'h1000, "R4 combined taken");
    br(2'd1, 0, 0, 5'b01000, 5'd2, 32'h0, 24'd8, 32'h1000, "R4 combined cond miss");
    br(2'd2, 0, 0, 5'b10100, 0, 0, 0, 32'h1000, "R6 lr target");
    br(2'd2, 0, 1, 5'b10100, 0, 0, 0, 32'h1000, "R8 lr target with link");
    br(2'd1, 0, 1, 5'b01100, 5'd1, 32'h0, 24'd8, 32'h1800, "R8 link not taken");
    idle(1, 0, 32'h3007, "R10 ctr load");
    br(2'd3, 0, 0, 5'b10100, 0, 0, 0, 32'h1000, "R6 ctr target");
    br(2'd3, 0, 0, 5'b10000, 0, 0, 0, 32'h1000, "R7 invalid ctr form");
    @(negedge clk);
    ctr_ld_i = 1; ld_data_i = 32'h99;
    br(2'd1, 0, 0, 5'b10100, 0, 0, 24'd8, 32'h1000, "R10 load ignored");
    idle(0, 0, 0, "R9 idle");
    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule